// File: doc/BRIEF.md
# Shared Byte FIFO with Fill-Level Alerts

This block is a single byte-wide queue of 64 entries. A host processor and an internal command engine both use it, for outgoing and for incoming data. The host reaches it through a write strobe and a read strobe. Which host strobes take effect depends on the command that is running. The engine has its own write strobe and pop strobe, and it sees the head byte at all times. One programmable threshold drives two alerts. The high alert warns that free space is running out. The low alert warns that the stored data is running low. Each alert has its own interrupt enable, and the enabled alerts combine onto one interrupt line.

When a write finds the queue full, the byte is lost and a sticky overflow flag is set. When the host makes an access that the current command does not permit, the access has no effect and a sticky access-error flag is set. A flush clears both flags and empties the queue in one cycle.

Top module: `sfifo_top`

## Requirements
- R1: After reset `fillLevel` is 0, and both `overflow` and `accessErr` are 0. `fillLevel` always reports the number of stored bytes, from 0 to 64.
- R2: Bytes leave in the order they were written, whichever side wrote them. A granted host read loads the head byte into `hostRdData` on the clock edge. `engRdData` shows the head byte whenever the queue is not empty.
- R3: A write while the queue holds 64 bytes is dropped and leaves the contents and the count unchanged. It sets `overflow`, which stays 1 until a flush.
- R4: A granted host read while the queue is empty sets `hostRdData` to 0x00 and leaves `fillLevel` unchanged.
- R5: A write and a read in the same cycle, with the queue neither empty nor full, leave `fillLevel` unchanged.
- R6: A cycle with `flush` high empties the queue and clears `overflow` and `accessErr`. Any host or engine access in that cycle has no effect. After a flush, 64 new bytes fit without an overflow.
- R7: `hiAlert` is 1 exactly when the free space (64 minus `fillLevel`) is less than or equal to `waterLevel`.
- R8: `loAlert` is 1 exactly when `fillLevel` is less than or equal to `waterLevel`.
- R9: `irq` is 1 exactly when (`hiIrqEn` and `hiAlert`) or (`loIrqEn` and `loAlert`).
- R10: `cmdState` sets which host accesses are allowed. Codes 0 and 1 allow none. Codes 2 and 3 allow writes only. Code 4 allows reads only. Code 5 allows both. Codes 6 and 7 allow none.
- R11: A host access that the current command does not allow leaves the contents, the count and `hostRdData` unchanged. It sets `accessErr`, which stays 1 until a flush.
- R12: An engine strobe takes precedence over a host strobe of the same direction in the same cycle. Only the engine byte is stored, and only one byte is popped. The host request is dropped without an error, so `hostRdData` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdState | input | 3 | Current command code, decoded as in R10 |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdEn | input | 1 | Host read strobe |
| hostRdData | output | 8 | Last byte the host read (registered) |
| engWrEn | input | 1 | Engine write strobe |
| engWrData | input | 8 | Engine write byte |
| engRdEn | input | 1 | Engine pop strobe |
| engRdData | output | 8 | Head byte of the queue |
| flush | input | 1 | Empty the queue and clear the flags |
| waterLevel | input | 6 | Alert threshold |
| hiIrqEn | input | 1 | Interrupt enable for the high alert |
| loIrqEn | input | 1 | Interrupt enable for the low alert |
| fillLevel | output | 7 | Number of stored bytes |
| overflow | output | 1 | Sticky flag: a write found the queue full |
| accessErr | output | 1 | Sticky flag: a host access was not allowed |
| hiAlert | output | 1 | Free space is at or below the threshold |
| loAlert | output | 1 | Stored bytes are at or below the threshold |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch every cycle for the properties that need no history. The count never exceeds 64 and never moves by more than one byte outside a flush. A flush leaves an empty queue with both flags clear, and both flags hold until a flush. A write into a full queue, or a host write under an idle command, sets the matching flag. Data ordering cannot be seen by a property, and neither can the value a read of an empty queue returns, engine precedence, or the alert thresholds across many water levels. The bench shows these by comparing every output against a reference queue model, first in directed corner cases and then in a long random run.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_STARTUP = 3'd1,
    CMD_SEND    = 3'd2,
    CMD_ARGS    = 3'd3,
    CMD_RECV    = 3'd4,
    CMD_XCHG    = 3'd5,
    CMD_RSV6    = 3'd6,
    CMD_RSV7    = 3'd7
  } cmd_e;

  // Strobes from the control side to the storage side
  typedef struct packed {
    logic push;       // store one byte this cycle
    logic useEng;     // the stored byte comes from the engine
    logic hostLoad;   // update the host read register
    logic hostEmpty;  // host read found the queue empty
  } fifo_strb_t;

  function automatic logic hostMayWrite(input cmd_e c);
    return (c == CMD_SEND) || (c == CMD_ARGS) || (c == CMD_XCHG);
  endfunction

  function automatic logic hostMayRead(input cmd_e c);
    return (c == CMD_RECV) || (c == CMD_XCHG);
  endfunction

endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    cmdState,
  input  logic          hostWrEn,
  input  logic          hostRdEn,
  input  logic          engWrEn,
  input  logic          engRdEn,
  input  logic          flush,
  input  logic [AW-1:0] waterLevel,
  input  logic          hiIrqEn,
  input  logic          loIrqEn,
  output fifo_strb_t    strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [AW:0]   fillLevel,
  output logic          overflow,
  output logic          accessErr,
  output logic          hiAlert,
  output logic          loAlert,
  output logic          irq
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(1 << AW);

  cmd_e          cmd;
  logic          wrAllowed, rdAllowed;
  logic          hostWrOk, hostRdOk, badAccess;
  logic          wrReq, rdReq, isFull, isEmpty;
  logic          doPush, doPop;
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count, freeSlots;
  logic          ovfQ, errQ;

  assign cmd       = cmd_e'(cmdState);
  assign wrAllowed = hostMayWrite(cmd);
  assign rdAllowed = hostMayRead(cmd);
  assign hostWrOk  = hostWrEn & wrAllowed;
  assign hostRdOk  = hostRdEn & rdAllowed;
  assign badAccess = (hostWrEn & ~wrAllowed) | (hostRdEn & ~rdAllowed);

  assign wrReq   = engWrEn | hostWrOk;
  assign rdReq   = engRdEn | hostRdOk;
  assign isFull  = (count == DEPTH_C);
  assign isEmpty = (count == '0);
  assign doPush  = ~flush & wrReq & ~isFull;
  assign doPop   = ~flush & rdReq & ~isEmpty;

  always_comb begin
    strb           = '0;
    strb.push      = doPush;
    strb.useEng    = engWrEn;
    strb.hostLoad  = ~flush & hostRdOk & ~engRdEn;
    strb.hostEmpty = isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovfQ  <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
      if (wrReq && isFull) ovfQ <= 1'b1;
      if (badAccess)       errQ <= 1'b1;
    end
  end

  assign freeSlots = DEPTH_C - count;
  assign hiAlert   = (freeSlots <= {1'b0, waterLevel});
  assign loAlert   = (count <= {1'b0, waterLevel});
  assign irq       = (hiIrqEn & hiAlert) | (loIrqEn & loAlert);

  assign wrAddr    = wrPtr;
  assign rdAddr    = rdPtr;
  assign fillLevel = count;
  assign overflow  = ovfQ;
  assign accessErr = errQ;

endmodule

// File: rtl/sfifo_data.sv
module sfifo_data
  import sfifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifo_strb_t    strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] hostWrData,
  input  logic [DW-1:0] engWrData,
  output logic [DW-1:0] hostRdData,
  output logic [DW-1:0] engRdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wrByte;
  logic [DW-1:0] rdQ;

  assign wrByte = strb.useEng ? engWrData : hostWrData;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrAddr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdQ <= '0;
    else if (strb.hostLoad) rdQ <= strb.hostEmpty ? '0 : mem[rdAddr];
  end

  assign hostRdData = rdQ;
  assign engRdData  = mem[rdAddr];

endmodule

// File: rtl/sfifo_top.sv
module sfifo_top
  import sfifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    cmdState,
  input  logic          hostWrEn,
  input  logic [DW-1:0] hostWrData,
  input  logic          hostRdEn,
  output logic [DW-1:0] hostRdData,
  input  logic          engWrEn,
  input  logic [DW-1:0] engWrData,
  input  logic          engRdEn,
  output logic [DW-1:0] engRdData,
  input  logic          flush,
  input  logic [AW-1:0] waterLevel,
  input  logic          hiIrqEn,
  input  logic          loIrqEn,
  output logic [AW:0]   fillLevel,
  output logic          overflow,
  output logic          accessErr,
  output logic          hiAlert,
  output logic          loAlert,
  output logic          irq
);
  fifo_strb_t    strb;
  logic [AW-1:0] wrAddr, rdAddr;

  sfifo_ctrl #(.AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdState(cmdState),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .engWrEn(engWrEn), .engRdEn(engRdEn), .flush(flush),
    .waterLevel(waterLevel), .hiIrqEn(hiIrqEn), .loIrqEn(loIrqEn),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fillLevel(fillLevel), .overflow(overflow), .accessErr(accessErr),
    .hiAlert(hiAlert), .loAlert(loAlert), .irq(irq)
  );

  sfifo_data #(.AW(AW), .DW(DW)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .hostWrData(hostWrData), .engWrData(engWrData),
    .hostRdData(hostRdData), .engRdData(engRdData)
  );

endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  cmdState,
  input logic        hostWrEn,
  input logic        hostRdEn,
  input logic        engWrEn,
  input logic        engRdEn,
  input logic        flush,
  input logic [AW:0] fillLevel,
  input logic        overflow,
  input logic        accessErr
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(1 << AW);

  // R1: the count never goes past the capacity
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= DEPTH_C);

  // R3: a lone write into a full queue is dropped and flagged
  a_r3_full_write: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == DEPTH_C && engWrEn && !engRdEn && !hostRdEn && !flush)
    |=> (overflow && fillLevel == DEPTH_C));

  // R3: the overflow flag holds until a flush
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !flush) |=> overflow);

  // R5: outside a flush the count moves by at most one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> (fillLevel == $past(fillLevel) ||
                fillLevel == $past(fillLevel) + 1'b1 ||
                fillLevel + 1'b1 == $past(fillLevel)));

  // R6: a flush empties the queue and clears both flags
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (fillLevel == '0 && !overflow && !accessErr));

  // R10: the idle command refuses host writes
  a_r10_idle_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmdState == 3'd0 && hostWrEn && !flush) |=> accessErr);

  // R11: the access error flag holds until a flush
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (accessErr && !flush) |=> accessErr);

endmodule

bind sfifo_top sfifo_chk #(.AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .cmdState(cmdState),
  .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .engWrEn(engWrEn), .engRdEn(engRdEn), .flush(flush),
  .fillLevel(fillLevel), .overflow(overflow), .accessErr(accessErr)
);

// File: tb/sfifo_top_tb_top.sv
`timescale 1ns/1ps
module sfifo_top_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    cmdState = 3'd0;
  logic          hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [DW-1:0] hostWrData = '0, engWrData = '0;
  logic          engWrEn = 1'b0, engRdEn = 1'b0, flush = 1'b0;
  logic [AW-1:0] waterLevel = '0;
  logic          hiIrqEn = 1'b0, loIrqEn = 1'b0;
  logic [DW-1:0] hostRdData, engRdData;
  logic [AW:0]   fillLevel;
  logic          overflow, accessErr, hiAlert, loAlert, irq;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  // reference model
  logic [DW-1:0] mq [$];
  logic          mOvf = 1'b0, mErr = 1'b0;
  logic [DW-1:0] mRd = '0;

  always #10 clk = ~clk;

  sfifo_top #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdState(cmdState),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .hostRdData(hostRdData), .engWrEn(engWrEn), .engWrData(engWrData),
    .engRdEn(engRdEn), .engRdData(engRdData), .flush(flush),
    .waterLevel(waterLevel), .hiIrqEn(hiIrqEn), .loIrqEn(loIrqEn),
    .fillLevel(fillLevel), .overflow(overflow), .accessErr(accessErr),
    .hiAlert(hiAlert), .loAlert(loAlert), .irq(irq)
  );

  function automatic bit allowWr(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3) || (c == 3'd5);
  endfunction
  function automatic bit allowRd(input logic [2:0] c);
    return (c == 3'd4) || (c == 3'd5);
  endfunction
  function automatic bit hiExp(input int n, input int wl);
    return (DEPTH - n) <= wl;
  endfunction
  function automatic bit loExp(input int n, input int wl);
    return n <= wl;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // Advance the model with the inputs now applied, as the clock edge will
  task automatic modelStep();
    bit hwOk, hrOk, wr, rd, full, empty;
    logic [DW-1:0] wb;
    if (flush) begin
      mq.delete();
      mOvf = 1'b0;
      mErr = 1'b0;
      return;
    end
    hwOk = hostWrEn && allowWr(cmdState);
    hrOk = hostRdEn && allowRd(cmdState);
    if ((hostWrEn && !hwOk) || (hostRdEn && !hrOk)) mErr = 1'b1;
    wr = engWrEn || hwOk;
    rd = engRdEn || hrOk;
    wb = engWrEn ? engWrData : hostWrData;
    full = (mq.size() == DEPTH);
    empty = (mq.size() == 0);
    if (hrOk && !engRdEn) mRd = empty ? 8'h00 : mq[0];
    if (rd && !empty) void'(mq.pop_front());
    if (wr) begin
      if (full) mOvf = 1'b1;
      else mq.push_back(wb);
    end
  endtask

  task automatic compareAll();
    bit h, l;
    h = hiExp(mq.size(), int'(waterLevel));
    l = loExp(mq.size(), int'(waterLevel));
    chk("R1 fillLevel", int'(fillLevel), mq.size());
    chk("R3 overflow", int'(overflow), int'(mOvf));
    chk("R11 accessErr", int'(accessErr), int'(mErr));
    chk("R7 hiAlert", int'(hiAlert), int'(h));
    chk("R8 loAlert", int'(loAlert), int'(l));
    chk("R9 irq", int'(irq), int'((hiIrqEn && h) || (loIrqEn && l)));
    chk("R2 hostRdData", int'(hostRdData), int'(mRd));
    if (mq.size() > 0) chk("R2 engRdData", int'(engRdData), int'(mq[0]));
  endtask

  // Inputs are applied at a falling edge; one rising edge; compare at the next falling edge
  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compareAll();
  endtask

  task automatic idleIn();
    hostWrEn = 0; hostRdEn = 0; engWrEn = 0; engRdEn = 0; flush = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    int seedDummy;
    int phase;
    seedDummy = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset fillLevel", int'(fillLevel), 0);
    chk("R1 reset overflow", int'(overflow), 0);
    chk("R1 reset accessErr", int'(accessErr), 0);
    compareAll();

    // Fill through host under a write-only command
    cmdState = 3'd2; waterLevel = 6'd4; hiIrqEn = 1; loIrqEn = 0;
    for (int i = 0; i < DEPTH; i++) begin
      idleIn(); hostWrEn = 1; hostWrData = 8'(i * 3 + 1);
      step();
    end
    chk("R7 hiAlert at full", int'(hiAlert), 1);
    chk("R9 irq at full", int'(irq), 1);
    idleIn(); engWrEn = 1; engWrData = 8'hEE;
    step();
    chk("R3 write when full count", int'(fillLevel), DEPTH);
    chk("R3 write when full flag", int'(overflow), 1);

    // Read-only command: read two, then a refused write
    cmdState = 3'd4;
    idleIn(); hostRdEn = 1; step();
    chk("R2 first byte", int'(hostRdData), 1);
    idleIn(); hostRdEn = 1; step();
    chk("R2 second byte", int'(hostRdData), 4);
    idleIn(); hostWrEn = 1; hostWrData = 8'h55; step();
    chk("R10 write refused under receive", int'(fillLevel), DEPTH - 2);
    chk("R11 error set", int'(accessErr), 1);
    cmdState = 3'd0;
    idleIn(); hostRdEn = 1; step();
    chk("R10 read refused under idle", int'(hostRdData), 4);

    // Flush wins over a same-cycle write
    cmdState = 3'd5;
    idleIn(); flush = 1; hostWrEn = 1; engWrEn = 1; step();
    chk("R6 flush count", int'(fillLevel), 0);
    chk("R6 flush overflow", int'(overflow), 0);
    chk("R6 flush error", int'(accessErr), 0);

    // Empty read
    idleIn(); hostRdEn = 1; step();
    chk("R4 empty read data", int'(hostRdData), 0);
    chk("R4 empty read count", int'(fillLevel), 0);

    // 64 fresh bytes fit after a flush
    cmdState = 3'd3;
    for (int i = 0; i < DEPTH; i++) begin
      idleIn(); hostWrEn = 1; hostWrData = 8'(200 - i); step();
    end
    chk("R6 refill count", int'(fillLevel), DEPTH);
    chk("R6 refill no overflow", int'(overflow), 0);
    idleIn(); flush = 1; step();

    // Simultaneous read and write
    cmdState = 3'd5;
    for (int i = 0; i < 3; i++) begin
      idleIn(); hostWrEn = 1; hostWrData = 8'(16 + i); step();
    end
    idleIn(); hostWrEn = 1; hostRdEn = 1; hostWrData = 8'h77; step();
    chk("R5 rd+wr count", int'(fillLevel), 3);
    chk("R5 rd+wr data", int'(hostRdData), 16);

    // Engine precedence
    idleIn(); engWrEn = 1; engWrData = 8'hA5; hostWrEn = 1; hostWrData = 8'h5A; step();
    chk("R12 one byte stored", int'(fillLevel), 4);
    idleIn(); engRdEn = 1; hostRdEn = 1; step();
    chk("R12 host read dropped", int'(hostRdData), 16);
    chk("R12 one byte popped", int'(fillLevel), 3);
    chk("R12 no error", int'(accessErr), 0);

    // Random run
    phase = 0;
    for (int n = 0; n < 6000; n++) begin
      if (n % 150 == 0) phase = int'($urandom_range(0, 1));
      if (n % 60 == 0) cmdState = 3'($urandom_range(0, 7));
      if (n % 97 == 0) begin
        waterLevel = AW'($urandom_range(0, DEPTH - 1));
        hiIrqEn = 1'($urandom_range(0, 1));
        loIrqEn = 1'($urandom_range(0, 1));
      end
      idleIn();
      if (phase == 0) begin
        hostWrEn = ($urandom_range(0, 99) < 60);
        engWrEn  = ($urandom_range(0, 99) < 20);
        hostRdEn = ($urandom_range(0, 99) < 15);
        engRdEn  = ($urandom_range(0, 99) < 5);
      end else begin
        hostWrEn = ($urandom_range(0, 99) < 10);
        engWrEn  = ($urandom_range(0, 99) < 10);
        hostRdEn = ($urandom_range(0, 99) < 50);
        engRdEn  = ($urandom_range(0, 99) < 25);
      end
      hostWrData = 8'($urandom);
      engWrData  = 8'($urandom);
      flush = ($urandom_range(0, 399) == 0);
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule